// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Register File

This block holds the configuration state of an interrupt router: an identification register, a fixed version word, an arbitration word, and a table of 64-bit redirection entries, one per interrupt pin. Software does not address these registers directly. It first writes a register number into a select register, then reads or writes the chosen register through a data window. Each table entry takes two register numbers, one for its lower word and one for its upper word.

A delivery engine next to the block reads any entry through a side port. It marks entries busy or free by setting and clearing their remote-IRR bit with strobes. The block tells that engine two things. It pulses `recalc_pulse` whenever a software write changes an entry field that affects routing or trigger mode. It raises `deliver_req` with the pin number when a software write leaves a pin unmasked, not busy, and with its input line asserted. The engine supplies the line state as `line_active`, one bit per pin, high while that pin's assertion count is above zero.

Entry field positions, which the engine decodes: vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12, polarity 13, remote IRR 14, trigger mode 15, mask 16, destination 63:56. Register numbers: identification 0x00, version 0x01, arbitration 0x02, and the table from 0x10 upward. Pin p uses number 0x10+2p for its lower word and 0x10+2p+1 for its upper word.

Top module: `ioidx_regfile`

## Requirements
- R1: An access is honoured only when `bus_size4` is high and `bus_offset` is 0x00 (select) or 0x10 (window). Any other read returns zero, and any other write changes no state.
- R2: The select register stores all 32 written bits and reads them back at offset 0x00. Only its low 8 bits choose the register reached through the window.
- R3: The version register reads 0x001F0011: the entry count minus one in bits 23:16, and code 0x11 in the low byte. Writes to it change nothing.
- R4: A write to the identification register keeps only bits 27:24 of the data. The arbitration register reads the same value, and writes to it change nothing.
- R5: After reset, every entry reads 0x0001000000010000 (all pins masked), the identification register reads zero, and both output strobes are low.
- R6: A window write to an entry replaces only the addressed 32-bit half. Remote IRR (bit 14) and delivery status (bit 12) keep their previous values.
- R7: `recalc_pulse` is high for exactly the cycle after an entry write that changed any bit other than mask (16) and polarity (13). It stays low when only those bits changed or nothing changed.
- R8: `deliver_req` is high for the cycle after an entry write when the resulting entry has mask 0 and remote IRR 0, and `line_active` for that pin was high during the write. `deliver_pin` then carries the pin number.
- R9: A window read of a register number that is neither 0x00, 0x01, 0x02 nor inside the table returns zero.
- R10: `irr_set_vld` sets remote IRR of pin `irr_set_pin`, and `irr_clr_vld` clears remote IRR of pin `irr_clr_pin`, both taking effect at the next clock edge. When both target the same pin in one cycle, the set wins.
- R11: `eng_entry` shows, without delay, the full 64-bit entry selected by `eng_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size4 | input | 1 | Access is a full 32-bit word |
| bus_offset | input | 8 | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| line_active | input | 32 | Per-pin line asserted (assertion count above zero) |
| eng_sel | input | 5 | Entry chosen for the side port |
| eng_entry | output | 64 | Contents of the chosen entry |
| irr_set_vld | input | 1 | Set remote IRR strobe |
| irr_set_pin | input | 5 | Pin whose remote IRR is set |
| irr_clr_vld | input | 1 | Clear remote IRR strobe |
| irr_clr_pin | input | 5 | Pin whose remote IRR is cleared |
| recalc_pulse | output | 1 | Routing or trigger fields of an entry changed |
| deliver_req | output | 1 | Request delivery for `deliver_pin` |
| deliver_pin | output | 5 | Pin of the delivery request |

## Verification
A corrupted read-only bit shows up at once, both in the next window read and on `eng_entry`. For example, remote IRR lost on a software write would let a second `deliver_req` appear one cycle after a rewrite of a busy pin. A wrong change detector either leaves `recalc_pulse` low after a vector or destination edit, or raises it after a mask or polarity flip; in both cases the error is visible one cycle after the write. A select register that decodes more than its low byte shows up as wrong window data on the very next read.

// File: rtl/ioidx_pkg.sv
package ioidx_pkg;

  localparam int DW    = 32;
  localparam int ENT_W = 64;

  // entry bit positions the delivery engine decodes
  localparam int B_DSTAT = 12;
  localparam int B_POL   = 13;
  localparam int B_RIRR  = 14;
  localparam int B_MASK  = 16;

  localparam logic [7:0] RN_ID  = 8'h00;
  localparam logic [7:0] RN_VER = 8'h01;
  localparam logic [7:0] RN_ARB = 8'h02;
  localparam logic [7:0] RN_TBL = 8'h10;

  localparam logic [7:0]  VER_CODE = 8'h11;
  localparam logic [31:0] ID_KEEP  = 32'h0F00_0000;

  typedef logic [ENT_W-1:0] entry_t;

  localparam entry_t ENTRY_RST  = 64'h0001_0000_0001_0000;
  localparam entry_t RO_BITS    = (entry_t'(1) << B_DSTAT) | (entry_t'(1) << B_RIRR);
  localparam entry_t NO_RECALC  = (entry_t'(1) << B_MASK) | (entry_t'(1) << B_POL);

  typedef struct packed {
    logic sel_wr;
    logic sel_rd;
    logic win_wr;
    logic win_rd;
  } acc_t;

  // merge one written half into an entry, keeping read-only bits
  function automatic entry_t merge_half(entry_t old, logic hi, logic [DW-1:0] d);
    entry_t w;
    w = hi ? {d, old[DW-1:0]} : {old[ENT_W-1:DW], d};
    return (w & ~RO_BITS) | (old & RO_BITS);
  endfunction

endpackage

// File: rtl/ioidx_bus_decode.sv
module ioidx_bus_decode
  import ioidx_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int OFS_W       = 8,
  localparam int PIN_W      = $clog2(NUM_ENTRIES)
) (
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic             bus_size4,
  input  logic [OFS_W-1:0] bus_offset,
  input  logic [7:0]       regnum,
  output acc_t             acc,
  output logic             is_id,
  output logic             is_ver,
  output logic             is_arb,
  output logic             ent_hit,
  output logic [PIN_W-1:0] ent_pin,
  output logic             ent_hi
);

  localparam logic [OFS_W-1:0] OFS_SEL = '0;
  localparam logic [OFS_W-1:0] OFS_WIN = OFS_W'(16);
  localparam logic [8:0]       TBL_SPAN = 9'(2 * NUM_ENTRIES);

  logic       honoured;
  logic [7:0] tbl_off;

  always_comb begin
    honoured   = bus_valid && bus_size4 &&
                 ((bus_offset == OFS_SEL) || (bus_offset == OFS_WIN));
    acc.sel_wr = honoured && bus_write  && (bus_offset == OFS_SEL);
    acc.sel_rd = honoured && !bus_write && (bus_offset == OFS_SEL);
    acc.win_wr = honoured && bus_write  && (bus_offset == OFS_WIN);
    acc.win_rd = honoured && !bus_write && (bus_offset == OFS_WIN);

    is_id   = (regnum == RN_ID);
    is_ver  = (regnum == RN_VER);
    is_arb  = (regnum == RN_ARB);
    tbl_off = regnum - RN_TBL;
    ent_hit = (regnum >= RN_TBL) && ({1'b0, tbl_off} < TBL_SPAN);
    ent_pin = tbl_off[PIN_W:1];
    ent_hi  = tbl_off[0];
  end

endmodule

// File: rtl/ioidx_entry_bank.sv
module ioidx_entry_bank
  import ioidx_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  localparam int PIN_W      = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PIN_W-1:0] wr_pin,
  input  logic             wr_hi,
  input  logic [DW-1:0]    wr_data,
  input  logic             set_vld,
  input  logic [PIN_W-1:0] set_pin,
  input  logic             clr_vld,
  input  logic [PIN_W-1:0] clr_pin,
  input  logic [PIN_W-1:0] rd_pin_a,
  output entry_t           rd_ent_a,
  input  logic [PIN_W-1:0] rd_pin_b,
  output entry_t           rd_ent_b
);

  entry_t ent_q [NUM_ENTRIES];

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    logic   hit_wr, hit_set, hit_clr, en;
    entry_t nxt;

    always_comb begin
      hit_wr  = wr_en   && (wr_pin  == PIN_W'(i));
      hit_set = set_vld && (set_pin == PIN_W'(i));
      hit_clr = clr_vld && (clr_pin == PIN_W'(i));
      en      = hit_wr || hit_set || hit_clr;
      nxt     = ent_q[i];
      if (hit_wr)  nxt = merge_half(ent_q[i], wr_hi, wr_data);
      if (hit_clr) nxt[B_RIRR] = 1'b0;
      if (hit_set) nxt[B_RIRR] = 1'b1;   // set wins over clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ent_q[i] <= ENTRY_RST;
      else if (en) ent_q[i] <= nxt;
    end
  end

  assign rd_ent_a = ent_q[rd_pin_a];
  assign rd_ent_b = ent_q[rd_pin_b];

endmodule

// File: rtl/ioidx_regfile.sv
module ioidx_regfile
  import ioidx_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int OFS_W       = 8,
  localparam int PIN_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_valid,
  input  logic                   bus_write,
  input  logic                   bus_size4,
  input  logic [OFS_W-1:0]       bus_offset,
  input  logic [DW-1:0]          bus_wdata,
  output logic [DW-1:0]          bus_rdata,
  input  logic [NUM_ENTRIES-1:0] line_active,
  input  logic [PIN_W-1:0]       eng_sel,
  output logic [ENT_W-1:0]       eng_entry,
  input  logic                   irr_set_vld,
  input  logic [PIN_W-1:0]       irr_set_pin,
  input  logic                   irr_clr_vld,
  input  logic [PIN_W-1:0]       irr_clr_pin,
  output logic                   recalc_pulse,
  output logic                   deliver_req,
  output logic [PIN_W-1:0]       deliver_pin
);

  localparam logic [DW-1:0] VER_WORD = {8'h00, 8'(NUM_ENTRIES - 1), 8'h00, VER_CODE};

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [DW-1:0]    sel_q, sel_d;
  logic [DW-1:0]    id_q, id_d;
  logic             sel_en, id_en;
  acc_t             acc;
  logic             is_id, is_ver, is_arb, ent_hit, ent_hi;
  logic [PIN_W-1:0] ent_pin;
  entry_t           cur_ent, new_ent;
  logic             ent_wr;
  logic             recalc_d, deliver_d;

  ioidx_bus_decode #(.NUM_ENTRIES(NUM_ENTRIES), .OFS_W(OFS_W)) u_dec (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_size4 (bus_size4),
    .bus_offset(bus_offset),
    .regnum    (sel_q[7:0]),
    .acc       (acc),
    .is_id     (is_id),
    .is_ver    (is_ver),
    .is_arb    (is_arb),
    .ent_hit   (ent_hit),
    .ent_pin   (ent_pin),
    .ent_hi    (ent_hi)
  );

  assign ent_wr = acc.win_wr && ent_hit;

  ioidx_entry_bank #(.NUM_ENTRIES(NUM_ENTRIES)) u_bank (
    .clk     (clk),
    .rst_n   (rst_ni),
    .wr_en   (ent_wr),
    .wr_pin  (ent_pin),
    .wr_hi   (ent_hi),
    .wr_data (bus_wdata),
    .set_vld (irr_set_vld),
    .set_pin (irr_set_pin),
    .clr_vld (irr_clr_vld),
    .clr_pin (irr_clr_pin),
    .rd_pin_a(ent_pin),
    .rd_ent_a(cur_ent),
    .rd_pin_b(eng_sel),
    .rd_ent_b(eng_entry)
  );

  // next state of select, id and the two event strobes
  always_comb begin
    sel_en    = acc.sel_wr;
    sel_d     = bus_wdata;
    id_en     = acc.win_wr && is_id;
    id_d      = bus_wdata & ID_KEEP;
    new_ent   = merge_half(cur_ent, ent_hi, bus_wdata);
    recalc_d  = ent_wr && (((cur_ent ^ new_ent) & ~NO_RECALC) != '0);
    deliver_d = ent_wr && !new_ent[B_MASK] && !new_ent[B_RIRR] &&
                line_active[ent_pin];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q        <= '0;
      id_q         <= '0;
      recalc_pulse <= 1'b0;
      deliver_req  <= 1'b0;
      deliver_pin  <= '0;
    end else begin
      if (sel_en)    sel_q <= sel_d;
      if (id_en)     id_q  <= id_d;
      recalc_pulse <= recalc_d;
      deliver_req  <= deliver_d;
      if (deliver_d) deliver_pin <= ent_pin;
    end
  end

  // read data
  always_comb begin
    bus_rdata = '0;
    if (acc.sel_rd) begin
      bus_rdata = sel_q;
    end else if (acc.win_rd) begin
      if (is_id || is_arb) bus_rdata = id_q;
      else if (is_ver)     bus_rdata = VER_WORD;
      else if (ent_hit)    bus_rdata = ent_hi ? cur_ent[ENT_W-1:DW] : cur_ent[DW-1:0];
    end
  end

endmodule

// File: rtl/ioidx_regfile_chk.sv
module ioidx_regfile_chk
  import ioidx_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int OFS_W       = 8,
  localparam int PIN_W      = $clog2(NUM_ENTRIES)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_valid,
  input logic                   bus_write,
  input logic                   bus_size4,
  input logic [OFS_W-1:0]       bus_offset,
  input logic [DW-1:0]          bus_wdata,
  input logic [DW-1:0]          bus_rdata,
  input logic [NUM_ENTRIES-1:0] line_active,
  input logic [PIN_W-1:0]       eng_sel,
  input logic [ENT_W-1:0]       eng_entry,
  input logic                   irr_set_vld,
  input logic [PIN_W-1:0]       irr_set_pin,
  input logic                   irr_clr_vld,
  input logic [PIN_W-1:0]       irr_clr_pin,
  input logic                   recalc_pulse,
  input logic                   deliver_req,
  input logic [PIN_W-1:0]       deliver_pin
);

  // the block leaves reset two edges after rst_n rises; track that window
  logic [1:0] live_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 2'b00;
    else        live_q <= {live_q[0], 1'b1};
  end

  logic ok, win_w, sel_w, sel_r, bad_r;
  assign ok    = live_q[1];
  assign win_w = bus_valid && bus_write && bus_size4 && (bus_offset == OFS_W'(16));
  assign sel_w = bus_valid && bus_write && bus_size4 && (bus_offset == '0);
  assign sel_r = bus_valid && !bus_write && bus_size4 && (bus_offset == '0);
  assign bad_r = bus_valid && !bus_write &&
                 (!bus_size4 || ((bus_offset != '0) && (bus_offset != OFS_W'(16))));

  assert_bad_access_zero_R1: assert property (@(posedge clk) disable iff (!ok)
    bad_r |-> (bus_rdata == '0));

  assert_sel_readback_R2: assert property (@(posedge clk) disable iff (!ok)
    sel_r && $past(sel_w) && $past(ok) |-> (bus_rdata == $past(bus_wdata)));

  assert_dstat_stays_clear_R6: assert property (@(posedge clk) disable iff (!ok)
    eng_entry[B_DSTAT] == 1'b0);

  assert_recalc_after_write_R7: assert property (@(posedge clk) disable iff (!ok)
    recalc_pulse |-> $past(win_w));

  assert_deliver_after_write_R8: assert property (@(posedge clk) disable iff (!ok)
    deliver_req |-> $past(win_w));

endmodule

bind ioidx_regfile ioidx_regfile_chk #(.NUM_ENTRIES(NUM_ENTRIES), .OFS_W(OFS_W)) u_chk (.*);

// File: tb/tb_ioidx_regfile.sv
module tb_ioidx_regfile;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write, bus_size4;
  logic [7:0]  bus_offset;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] line_active;
  logic [4:0]  eng_sel;
  logic [63:0] eng_entry;
  logic        irr_set_vld, irr_clr_vld;
  logic [4:0]  irr_set_pin, irr_clr_pin;
  logic        recalc_pulse, deliver_req;
  logic [4:0]  deliver_pin;

  int total = 0;
  int bad   = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;   // 250 MHz

  ioidx_regfile dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: compares each read result against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && bus_valid && !bus_write) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard act=%h exp=none", bus_rdata);
      end else begin
        chk(tag_q.pop_front(), {32'h0, bus_rdata}, {32'h0, exp_q.pop_front()});
      end
    end
  end

  task automatic bus_wr(logic [7:0] ofs, logic [31:0] d, logic sz4 = 1'b1);
    @(posedge clk); #1;
    bus_valid = 1'b1; bus_write = 1'b1; bus_size4 = sz4;
    bus_offset = ofs; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] ofs, logic [31:0] exp, string tag, logic sz4 = 1'b1);
    @(posedge clk); #1;
    bus_valid = 1'b1; bus_write = 1'b0; bus_size4 = sz4; bus_offset = ofs;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_valid = 1'b0;
  endtask

  task automatic reg_wr(logic [7:0] rn, logic [31:0] d);
    bus_wr(8'h00, {24'h0, rn});
    bus_wr(8'h10, d);
  endtask

  task automatic reg_rd(logic [7:0] rn, logic [31:0] exp, string tag);
    bus_wr(8'h00, {24'h0, rn});
    bus_rd(8'h10, exp, tag);
  endtask

  // entry write, then check both strobes in the cycle after the write
  task automatic ent_wr(logic [7:0] rn, logic [31:0] d, logic e_rc, logic e_dv,
                        logic [4:0] e_pin, string tag);
    bus_wr(8'h00, {24'h0, rn});
    bus_wr(8'h10, d);
    chk({"R7 recalc ", tag}, {63'h0, recalc_pulse}, {63'h0, e_rc});
    chk({"R8 deliver ", tag}, {63'h0, deliver_req}, {63'h0, e_dv});
    if (e_dv) chk({"R8 pin ", tag}, {59'h0, deliver_pin}, {59'h0, e_pin});
  endtask

  task automatic irr_pulse(logic s, logic [4:0] sp, logic c, logic [4:0] cp);
    @(posedge clk); #1;
    irr_set_vld = s; irr_set_pin = sp; irr_clr_vld = c; irr_clr_pin = cp;
    @(posedge clk); #1;
    irr_set_vld = 1'b0; irr_clr_vld = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bus_valid = 1'b0; bus_write = 1'b0; bus_size4 = 1'b1;
    bus_offset = '0; bus_wdata = '0; line_active = '0; eng_sel = '0;
    irr_set_vld = 1'b0; irr_clr_vld = 1'b0; irr_set_pin = '0; irr_clr_pin = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R5 reset state
    chk("R5 recalc idle", {63'h0, recalc_pulse}, 64'h0);
    chk("R5 deliver idle", {63'h0, deliver_req}, 64'h0);
    eng_sel = 5'd5; #1;
    chk("R5 R11 entry 5", eng_entry, 64'h0001_0000_0001_0000);
    reg_rd(8'h00, 32'h0, "R5 id");
    reg_rd(8'h10, 32'h0001_0000, "R5 pin0 low");
    reg_rd(8'h4E, 32'h0001_0000, "R5 pin31 low");
    reg_rd(8'h4F, 32'h0001_0000, "R5 pin31 high");

    // R2 select register and low-byte decode
    bus_wr(8'h00, 32'h1234_5678);
    bus_rd(8'h00, 32'h1234_5678, "R2 select readback");
    bus_rd(8'h10, 32'h0, "R2 R9 regnum 0x78");
    bus_wr(8'h00, 32'hABCD_0001);
    bus_rd(8'h10, 32'h001F_0011, "R2 upper select bits ignored");

    // R3 version
    reg_rd(8'h01, 32'h001F_0011, "R3 version");
    reg_wr(8'h01, 32'hFFFF_FFFF);
    reg_rd(8'h01, 32'h001F_0011, "R3 version after write");

    // R4 identification and arbitration
    reg_wr(8'h00, 32'hFFFF_FFFF);
    reg_rd(8'h00, 32'h0F00_0000, "R4 id masked");
    reg_rd(8'h02, 32'h0F00_0000, "R4 arb mirrors id");
    reg_wr(8'h02, 32'h0000_0000);
    reg_rd(8'h00, 32'h0F00_0000, "R4 arb write ignored");
    bus_wr(8'h00, 32'h0000_0100);
    bus_rd(8'h10, 32'h0F00_0000, "R2 R4 select 0x100 hits id");

    // R9 unknown numbers
    reg_rd(8'h05, 32'h0, "R9 regnum 0x05");
    reg_rd(8'h50, 32'h0, "R9 regnum 0x50");

    // R6 R7 half write, read-only bits, masked pin
    ent_wr(8'h16, 32'hFFFF_FFFF, 1'b1, 1'b0, 5'd0, "pin3 low");
    reg_rd(8'h16, 32'hFFFF_AFFF, "R6 pin3 low ro kept");
    reg_rd(8'h17, 32'h0001_0000, "R6 pin3 high untouched");

    // R7 mask and polarity only
    ent_wr(8'h18, 32'h0000_2000, 1'b0, 1'b0, 5'd0, "pin4 mask pol only");
    reg_rd(8'h18, 32'h0000_2000, "R6 pin4 low");

    // R1 illegal size and offset
    bus_wr(8'h00, 32'h0000_0018);
    bus_wr(8'h10, 32'hFFFF_FFFF, 1'b0);
    bus_wr(8'h04, 32'h0000_0001);
    bus_rd(8'h00, 32'h0000_0018, "R1 select kept after bad write");
    bus_rd(8'h10, 32'h0000_2000, "R1 entry kept after short write");
    bus_rd(8'h10, 32'h0, "R1 short read zero", 1'b0);
    bus_rd(8'h20, 32'h0, "R1 offset 0x20 zero");

    // R8 unmask with line asserted
    line_active = 32'h0000_0040;
    ent_wr(8'h1C, 32'h0000_0041, 1'b1, 1'b1, 5'd6, "pin6 unmask");

    // R10 remote IRR strobes
    irr_pulse(1'b1, 5'd6, 1'b0, 5'd0);
    eng_sel = 5'd6; #1;
    chk("R10 R11 pin6 irr set", eng_entry, 64'h0001_0000_0000_4041);
    ent_wr(8'h1C, 32'h0000_0041, 1'b0, 1'b0, 5'd0, "pin6 busy rewrite");
    reg_rd(8'h1C, 32'h0000_4041, "R6 irr survives write");
    irr_pulse(1'b0, 5'd0, 1'b1, 5'd6);
    reg_rd(8'h1C, 32'h0000_0041, "R10 irr clear");
    irr_pulse(1'b1, 5'd6, 1'b1, 5'd6);
    reg_rd(8'h1C, 32'h0000_4041, "R10 set wins");
    irr_pulse(1'b0, 5'd0, 1'b1, 5'd6);

    // R7 R8 upper half write on live pin
    ent_wr(8'h1D, 32'hAB00_0000, 1'b1, 1'b1, 5'd6, "pin6 dest");
    reg_rd(8'h1D, 32'hAB00_0000, "R6 pin6 high");
    #1;
    chk("R11 pin6 full", eng_entry, 64'hAB00_0000_0000_0041);

    // R8 line low: no request
    ent_wr(8'h1E, 32'h0000_0030, 1'b1, 1'b0, 5'd0, "pin7 line low");

    repeat (3) @(posedge clk);
    chk("scoreboard drained", 64'(exp_q.size()), 64'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule